// File: doc/BRIEF.md
# Byte-Lane Steering Memory Access Unit

This unit sits between a 16-bit processing core and a 16-bit memory bus that is built from two 8-bit byte lanes. The core issues byte or word reads and writes at a 20-bit byte address. The unit works out which lane or lanes each access uses and drives the byte enables to match. It places write bytes on the correct lanes and collects read bytes back into a result that has the low byte at the lower address.

A word at an even address goes out as one bus cycle with both lanes enabled. A word at an odd address straddles two bus words. The unit splits it into two bus cycles: the high lane of the even-aligned word at A comes first, then the low lane of the next bus word. The address is incremented modulo 2^20. The core pulses a one-cycle request and waits for a one-cycle done pulse. Request pulses that arrive while an access is in flight are dropped.

Top module: `mem_lane_steer`

## Requirements
- R1: A byte access at an even address A is one bus cycle with bus_addr = A, ble = 1, bhe = 0. A read returns {8'h00, bus_rdata[7:0]} on req_rdata.
- R2: A byte access at an odd address A is one bus cycle with bus_addr = A with bit 0 cleared, bhe = 1, ble = 0. A read returns {8'h00, bus_rdata[15:8]}.
- R3: A word access at an even address A is exactly one bus cycle with bus_addr = A and both enables high. A write drives req_wdata unchanged on bus_wdata. A read returns bus_rdata unchanged.
- R4: A word access at an odd address A is two bus cycles. The first has bus_addr = A with bit 0 cleared, bhe = 1, ble = 0. The second has bus_addr = (A + 1) mod 2^20, ble = 1, bhe = 0.
- R5: Words are little-endian. On an odd-word write, bus_wdata is the byte-swapped req_wdata in both cycles, so the low byte lands at A on the high lane and the high byte lands at A+1 on the low lane. On an odd-word read, req_rdata[7:0] is the high lane of the first cycle and req_rdata[15:8] is the low lane of the second cycle.
- R6: While bus_valid is high, bus_addr bit 0 is 0 and at least one byte enable is high.
- R7: While bus_valid is high and bus_ack is low, bus_valid, bus_addr, the enables and bus_wdata hold their values into the next cycle.
- R8: req_ready is high for exactly one cycle, in the cycle after the final bus cycle of the request is acknowledged, and bus_valid is low in that cycle.
- R9: A req_valid pulse that arrives while an access is in progress is ignored. It causes no bus cycle, no req_ready pulse and no memory change.
- R10: After reset, bus_valid and req_ready are 0.
- R11: A byte write drives the byte on both lanes: bus_wdata = {req_wdata[7:0], req_wdata[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request pulse, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| req_ready | output | 1 | One-cycle done pulse |
| req_rdata | output | 16 | Read result, valid while req_ready is high |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_addr | output | 20 | Even-aligned bus address |
| bus_bhe | output | 1 | Upper lane (bits 15:8) enable, active high |
| bus_ble | output | 1 | Lower lane (bits 7:0) enable, active high |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, sampled with bus_ack |
| bus_ack | input | 1 | Bus cycle completes in a cycle where it is high with bus_valid |

## Verification
The following properties are checked on every cycle:
- every bus address is even and carries at least one enable;
- the bus outputs hold steady through wait states;
- the done pulse lasts one cycle, follows an acknowledge and never overlaps a bus cycle.

The rest can only be shown by the bench's scenarios against a byte-wide memory model:
- which lane a given address picks;
- the order of the two halves of a split word and the wrap at the top of the address space;
- the byte swap of write data;
- reassembly of read results;
- that a request pulse during a split leaves memory untouched.

// File: rtl/mls_pkg.sv
package mls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2,
      ST_DONE   = 2'd3
   } mls_state_t;

   typedef struct packed {
      logic write;
      logic word;
      logic odd;
   } mls_kind_t;
endpackage

// File: rtl/mls_ctrl.sv
module mls_ctrl
   import mls_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       split,
   input  logic       bus_ack,
   output logic       accept,
   output logic       bus_active,
   output logic       phase2,
   output logic       done
);
   mls_state_t state, state_nx;

   assign accept     = (state == ST_IDLE) && req_valid;
   assign bus_active = (state == ST_FIRST) || (state == ST_SECOND);
   assign phase2     = (state == ST_SECOND);
   assign done       = (state == ST_DONE);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
         ST_FIRST:  if (bus_ack) state_nx = split ? ST_SECOND : ST_DONE;
         ST_SECOND: if (bus_ack) state_nx = ST_DONE;
         ST_DONE:   state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/mls_lane_map.sv
module mls_lane_map
   import mls_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int LANE_W    = 8,
   parameter bit REPLICATE = 1'b1
) (
   input  logic [ADDR_W-1:0]   addr,
   input  mls_kind_t           kind,
   input  logic                phase2,
   input  logic [2*LANE_W-1:0] wdata,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                bhe,
   output logic                ble,
   output logic [2*LANE_W-1:0] bus_wdata
);
   localparam int DATA_W = 2 * LANE_W;

   logic [ADDR_W-1:0] base, base_next;
   logic [DATA_W-1:0] byte_data;

   assign base      = {addr[ADDR_W-1:1], 1'b0};
   assign base_next = base + ADDR_W'(2);
   assign bus_addr  = phase2 ? base_next : base;

   always_comb begin
      if (kind.word && !kind.odd) begin
         bhe = 1'b1;
         ble = 1'b1;
      end else if (kind.word) begin
         bhe = !phase2;
         ble = phase2;
      end else begin
         bhe = kind.odd;
         ble = !kind.odd;
      end
   end

   generate
      if (REPLICATE) begin : g_repl
         assign byte_data = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
      end else begin : g_zero
         assign byte_data = kind.odd ? {wdata[LANE_W-1:0], {LANE_W{1'b0}}}
                                     : {{LANE_W{1'b0}}, wdata[LANE_W-1:0]};
      end
   endgenerate

   always_comb begin
      if (!kind.word)   bus_wdata = byte_data;
      else if (kind.odd) bus_wdata = {wdata[LANE_W-1:0], wdata[DATA_W-1:LANE_W]};
      else               bus_wdata = wdata;
   end
endmodule

// File: rtl/mls_assemble.sv
module mls_assemble
   import mls_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic                phase2,
   input  mls_kind_t           kind,
   input  logic [2*LANE_W-1:0] bus_rdata,
   output logic [2*LANE_W-1:0] rdata
);
   localparam int DATA_W = 2 * LANE_W;

   logic [LANE_W-1:0] lane_lo, lane_hi;
   assign lane_lo = bus_rdata[LANE_W-1:0];
   assign lane_hi = bus_rdata[DATA_W-1:LANE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         if (phase2)                      rdata[DATA_W-1:LANE_W] <= lane_lo;
         else if (kind.word && !kind.odd) rdata <= bus_rdata;
         else if (kind.word)              rdata[LANE_W-1:0] <= lane_hi;
         else rdata <= {{LANE_W{1'b0}}, kind.odd ? lane_hi : lane_lo};
      end
   end
endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
   import mls_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int LANE_W    = 8,
   parameter bit REPLICATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_word,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*LANE_W-1:0] req_wdata,
   output logic                req_ready,
   output logic [2*LANE_W-1:0] req_rdata,
   output logic                bus_valid,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                bus_bhe,
   output logic                bus_ble,
   output logic [2*LANE_W-1:0] bus_wdata,
   input  logic [2*LANE_W-1:0] bus_rdata,
   input  logic                bus_ack
);
   localparam int DATA_W = 2 * LANE_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mem_lane_steer: ADDR_W must be at least 2");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("mem_lane_steer: LANE_W must be at least 1");
      end
   endgenerate

   logic              accept, phase2;
   logic [ADDR_W-1:0] r_addr;
   logic [DATA_W-1:0] r_wdata;
   mls_kind_t         r_kind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_addr  <= '0;
         r_wdata <= '0;
         r_kind  <= '0;
      end else if (accept) begin
         r_addr     <= req_addr;
         r_wdata    <= req_wdata;
         r_kind.write <= req_write;
         r_kind.word  <= req_word;
         r_kind.odd   <= req_addr[0];
      end
   end

   mls_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .split      (r_kind.word && r_kind.odd),
      .bus_ack    (bus_ack),
      .accept     (accept),
      .bus_active (bus_valid),
      .phase2     (phase2),
      .done       (req_ready)
   );

   mls_lane_map #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .REPLICATE(REPLICATE)) u_map (
      .addr      (r_addr),
      .kind      (r_kind),
      .phase2    (phase2),
      .wdata     (r_wdata),
      .bus_addr  (bus_addr),
      .bhe       (bus_bhe),
      .ble       (bus_ble),
      .bus_wdata (bus_wdata)
   );

   mls_assemble #(.LANE_W(LANE_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (bus_valid && bus_ack && !r_kind.write),
      .phase2    (phase2),
      .kind      (r_kind),
      .bus_rdata (bus_rdata),
      .rdata     (req_rdata)
   );
endmodule

// File: rtl/mem_lane_steer_chk.sv
module mem_lane_steer_chk #(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                bus_valid,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_bhe,
   input logic                bus_ble,
   input logic [2*LANE_W-1:0] bus_wdata,
   input logic                bus_ack
);
   a_r6_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !bus_addr[0]);

   a_r6_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_bhe || bus_ble));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_bhe)
                                   && $stable(bus_ble) && $stable(bus_wdata)));

   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   a_r8_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> $past(bus_valid && bus_ack));

   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_valid);
endmodule

bind mem_lane_steer mem_lane_steer_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/mem_lane_steer_test.sv
module mem_lane_steer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] req_rdata;
   logic        bus_valid, bus_bhe, bus_ble;
   logic [19:0] bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mem_lane_steer uut (.*);

   typedef struct {
      logic [19:0] addr;
      logic        bhe, ble, wr;
      logic [15:0] wdata;
      string       tag;
   } bus_item_t;

   typedef struct {
      logic        rd;
      logic [15:0] data;
      string       tag;
   } res_item_t;

   bus_item_t bus_q[$];
   res_item_t res_q[$];
   logic [7:0] mem [int];

   function automatic logic [7:0] rd_byte(logic [19:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bus responder and bus-side monitor
   int wait_cnt = 0;
   int wait_tgt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
      end else if (bus_ack) begin
         bus_ack <= 1'b0;
      end else if (bus_valid) begin
         if (wait_cnt < wait_tgt) begin
            wait_cnt++;
         end else begin
            if (bus_q.size() == 0) begin
               check("R9 unexpected bus cycle", {12'h0, bus_addr}, 32'hFFFFFFFF);
            end else begin
               bus_item_t e;
               e = bus_q.pop_front();
               check({e.tag, " bus_addr"}, {12'h0, bus_addr}, {12'h0, e.addr});
               check({e.tag, " enables"}, {30'h0, bus_bhe, bus_ble}, {30'h0, e.bhe, e.ble});
               if (e.wr) check({e.tag, " bus_wdata"}, {16'h0, bus_wdata}, {16'h0, e.wdata});
            end
            bus_rdata <= {rd_byte(bus_addr | 20'h1), rd_byte(bus_addr & ~20'h1)};
            if (bus_wdata !== 16'hxxxx) begin end
            bus_ack <= 1'b1;
            wait_cnt = 0;
            wait_tgt = (wait_tgt + 1) % 3;
         end
      end
   end

   // model write on acknowledged write cycles (design samples at the posedge)
   logic last_write;
   always @(posedge clk) begin
      if (rst_n && bus_valid && bus_ack && last_write) begin
         if (bus_bhe) mem[int'(bus_addr | 20'h1)] = bus_wdata[15:8];
         if (bus_ble) mem[int'(bus_addr)] = bus_wdata[7:0];
      end
   end

   // core-side monitor
   always @(negedge clk) begin
      if (rst_n && req_ready) begin
         if (res_q.size() == 0) begin
            check("R9 unexpected req_ready", 32'h1, 32'h0);
         end else begin
            res_item_t r;
            r = res_q.pop_front();
            if (r.rd) check({r.tag, " req_rdata"}, {16'h0, req_rdata}, {16'h0, r.data});
         end
      end
   end

   task automatic do_req(logic wr, logic wd, logic [19:0] a, logic [15:0] d,
                         string tag, bit intrude);
      bus_item_t b;
      res_item_t r;
      logic [19:0] a1;
      a1 = a + 20'h1;
      b.wr = wr; b.tag = tag;
      if (!wd) begin
         b.addr = a & ~20'h1; b.bhe = a[0]; b.ble = !a[0];
         b.wdata = {d[7:0], d[7:0]};
         bus_q.push_back(b);
         r.data = {8'h00, rd_byte(a)};
      end else if (!a[0]) begin
         b.addr = a; b.bhe = 1'b1; b.ble = 1'b1; b.wdata = d;
         bus_q.push_back(b);
         r.data = {rd_byte(a1), rd_byte(a)};
      end else begin
         b.addr = a & ~20'h1; b.bhe = 1'b1; b.ble = 1'b0; b.wdata = {d[7:0], d[15:8]};
         bus_q.push_back(b);
         b.addr = a1; b.bhe = 1'b0; b.ble = 1'b1;
         bus_q.push_back(b);
         r.data = {rd_byte(a1), rd_byte(a)};
      end
      r.rd = !wr; r.tag = tag;
      res_q.push_back(r);
      @(negedge clk);
      last_write = wr;
      req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (intrude) begin
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
         req_addr = 20'h00400; req_wdata = 16'hDEAD;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (!req_ready) @(negedge clk);
      req_write = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check("watchdog", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      last_write = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 bus_valid after reset", {31'h0, bus_valid}, 32'h0);
      check("R10 req_ready after reset", {31'h0, req_ready}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 bus_valid idle", {31'h0, bus_valid}, 32'h0);

      do_req(1'b0, 1'b0, 20'h12344, 16'h0, "R1 byte read even", 1'b0);
      do_req(1'b0, 1'b0, 20'h12345, 16'h0, "R2 byte read odd", 1'b0);
      do_req(1'b0, 1'b1, 20'h0ABC0, 16'h0, "R3 word read even", 1'b0);
      do_req(1'b0, 1'b1, 20'h0ABC3, 16'h0, "R4 word read odd", 1'b0);
      do_req(1'b1, 1'b0, 20'h00010, 16'h00A1, "R11 byte write even", 1'b0);
      do_req(1'b1, 1'b0, 20'h00011, 16'h00B2, "R11 byte write odd", 1'b0);
      do_req(1'b0, 1'b1, 20'h00010, 16'h0, "R3 readback of byte writes", 1'b0);
      do_req(1'b1, 1'b1, 20'h00020, 16'hC3D4, "R3 word write even", 1'b0);
      do_req(1'b0, 1'b0, 20'h00021, 16'h0, "R2 readback high byte", 1'b0);
      do_req(1'b1, 1'b1, 20'h00031, 16'h5566, "R5 word write odd", 1'b0);
      do_req(1'b0, 1'b0, 20'h00031, 16'h0, "R5 low byte at A", 1'b0);
      do_req(1'b0, 1'b0, 20'h00032, 16'h0, "R5 high byte at A+1", 1'b0);
      do_req(1'b0, 1'b1, 20'h00031, 16'h0, "R5 odd word readback", 1'b0);
      do_req(1'b1, 1'b1, 20'hFFFFF, 16'h7788, "R4 wrap write", 1'b0);
      do_req(1'b0, 1'b0, 20'h00000, 16'h0, "R4 wrap high byte at 0", 1'b0);
      do_req(1'b0, 1'b1, 20'hFFFFF, 16'h0, "R4 wrap read", 1'b0);
      do_req(1'b0, 1'b1, 20'h00101, 16'h0, "R9 split with intruder", 1'b1);
      do_req(1'b0, 1'b1, 20'h00400, 16'h0, "R9 intruder left memory", 1'b0);
      repeat (10) @(negedge clk);
      check("R9 no leftover bus items", bus_q.size(), 32'h0);
      check("R8 no leftover results", res_q.size(), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule